// File: doc/BRIEF.md
# MESI Coherence Line State Controller

This block keeps the coherence state of every line of one cache in a small snooping multiprocessor. Each line carries a two-bit state: Modified, Exclusive, Shared or Invalid. The block serves local read and write requests from its own processor. It also watches the bus traffic of the other processors: reads, reads-for-ownership and invalidates. For each event it works out the new line state, the bus transaction the cache must issue, and the shared response that tells another cache filling the same line that a copy exists here.

Each cycle carries at most one local request and at most one snoop. A snoop takes precedence: while one is active the local port is held off through a ready signal. A local read miss samples the shared-line input in the same cycle, so a fill lands in Exclusive when no other cache holds the line, and in Shared when one does. A snoop that hits a Modified line produces a write-back. Line state updates in one cycle. The bus command and the update report are registered and appear one cycle after the request. The hit and shared-response outputs are combinational.

Top module: `mesi_coherence_ctrl`

## Requirements
- R1: After reset every line is Invalid, `bus_cmd_o` is 0 (no command) and `upd_valid_o` is low.
- R2: State codes are Invalid=2'b00, Shared=2'b01, Exclusive=2'b10, Modified=2'b11. Bus command codes are none=0, read=1, read-for-ownership=2, invalidate=3, write-back=4. Snoop kind codes are read=0, read-for-ownership=1, invalidate=2, reserved=3.
- R3: A local read of an Invalid line issues a read command. The line becomes Exclusive if `shared_in_i` is low in the request cycle, and Shared if it is high.
- R4: A local read of a valid line issues no command and leaves the state unchanged. `lcl_hit_o` is high in the same cycle whenever the addressed line is not Invalid.
- R5: A local write moves the line to Modified. From Invalid it issues read-for-ownership. From Shared it issues invalidate. From Exclusive or Modified it issues no command.
- R6: A snooped read moves a Modified line to Shared with a write-back, moves an Exclusive line to Shared, and leaves a Shared line Shared. `snp_shared_o` is high in the same cycle exactly when a snooped read addresses a non-Invalid line.
- R7: A snooped read-for-ownership or invalidate moves any valid line to Invalid, and issues a write-back if the line was Modified.
- R8: While a snoop of kind 0 to 2 is presented, `lcl_ready_o` is low and any local request in that cycle has no effect.
- R9: A snoop of the reserved kind 3 changes no state, issues no command and does not hold off a local request.
- R10: A snoop to an Invalid line changes nothing, issues no command and raises no update.
- R11: Bus command, `bus_line_o`, `upd_valid_o`, `upd_line_o` and `upd_state_o` are registered and appear one cycle after the request. `upd_valid_o` pulses for every accepted local request and for every snoop of kind 0 to 2 that hits a valid line, and reports the line and its new state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lcl_valid_i | input | 1 | Local request present |
| lcl_write_i | input | 1 | Local request is a write (0 = read) |
| lcl_line_i | input | IDX_W | Line addressed by the local request |
| shared_in_i | input | 1 | Another cache holds the line being filled |
| lcl_ready_o | output | 1 | Local request accepted this cycle |
| lcl_hit_o | output | 1 | Local line is not Invalid |
| snp_valid_i | input | 1 | Snooped bus transaction present |
| snp_kind_i | input | 2 | Snooped transaction kind |
| snp_line_i | input | IDX_W | Line addressed by the snoop |
| snp_shared_o | output | 1 | Shared response to a snooped read |
| bus_cmd_o | output | 3 | Bus command to issue |
| bus_line_o | output | IDX_W | Line the bus command refers to |
| upd_valid_o | output | 1 | A line state was written |
| upd_line_o | output | IDX_W | Line that was written |
| upd_state_o | output | 2 | New state of that line |

## Verification
The assertions assume the inputs are clean binary values from the first clock edge after reset. They also assume a snoop of kind 0 to 2 comes from another processor whose bus protocol is legal, so a write-back only ever follows a snoop. The stimulus drives every input at the falling edge, one event per cycle. It applies snoops only to lines whose states come from earlier accepted requests. Overlapping local and snoop traffic appears only in the dedicated priority and reserved-kind cases.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

  typedef enum logic [1:0] {
    ST_I = 2'b00,
    ST_S = 2'b01,
    ST_E = 2'b10,
    ST_M = 2'b11
  } line_state_e;

  typedef enum logic [2:0] {
    BUS_NONE = 3'd0,
    BUS_RD   = 3'd1,
    BUS_RFO  = 3'd2,
    BUS_UPGR = 3'd3,
    BUS_WB   = 3'd4
  } bus_cmd_e;

  typedef enum logic [1:0] {
    SNP_RD   = 2'd0,
    SNP_RFO  = 2'd1,
    SNP_INV  = 2'd2,
    SNP_RSVD = 2'd3
  } snoop_kind_e;

  typedef struct packed {
    line_state_e nxt;
    bus_cmd_e    cmd;
  } step_t;

  function automatic logic holds_copy(line_state_e s);
    return s != ST_I;
  endfunction

  // Local processor access: next state and bus command.
  function automatic step_t local_step(line_state_e cur, logic wr, logic other_has);
    step_t r;
    r.nxt = cur;
    r.cmd = BUS_NONE;
    if (wr) begin
      r.nxt = ST_M;
      case (cur)
        ST_I:    r.cmd = BUS_RFO;
        ST_S:    r.cmd = BUS_UPGR;
        default: r.cmd = BUS_NONE;
      endcase
    end else if (cur == ST_I) begin
      r.cmd = BUS_RD;
      r.nxt = other_has ? ST_S : ST_E;
    end
    return r;
  endfunction

  // Snooped foreign transaction: next state and bus command.
  function automatic step_t snoop_step(line_state_e cur, snoop_kind_e k);
    step_t r;
    r.nxt = cur;
    r.cmd = BUS_NONE;
    if (holds_copy(cur) && k != SNP_RSVD) begin
      r.cmd = (cur == ST_M) ? BUS_WB : BUS_NONE;
      r.nxt = (k == SNP_RD) ? ST_S : ST_I;
    end
    return r;
  endfunction

endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
  import mesi_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int IDX_W     = $clog2(NUM_LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_line,
  input  line_state_e       wr_state,
  input  logic [IDX_W-1:0]  rd_a_line,
  output line_state_e       rd_a_state,
  input  logic [IDX_W-1:0]  rd_b_line,
  output line_state_e       rd_b_state
);

  line_state_e st_q [NUM_LINES];

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        st_q[g] <= ST_I;
      else if (wr_en && wr_line == IDX_W'(g))
        st_q[g] <= wr_state;
    end
  end

  assign rd_a_state = st_q[rd_a_line];
  assign rd_b_state = st_q[rd_b_line];

endmodule

// File: rtl/mesi_txn_select.sv
module mesi_txn_select
  import mesi_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             lcl_valid,
  input  logic             lcl_write,
  input  logic [IDX_W-1:0] lcl_line,
  input  line_state_e      lcl_cur,
  input  logic             shared_in,
  input  logic             snp_valid,
  input  snoop_kind_e      snp_kind,
  input  logic [IDX_W-1:0] snp_line,
  input  line_state_e      snp_cur,
  output logic             sel_snoop,
  output logic             lcl_ready,
  output logic             lcl_hit,
  output logic             snp_shared,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_line,
  output line_state_e      wr_state,
  output bus_cmd_e         cmd
);

  step_t lcl_res;
  step_t snp_res;
  logic  snp_active;

  always_comb begin
    snp_active = snp_valid && (snp_kind != SNP_RSVD);
    lcl_res    = local_step(lcl_cur, lcl_write, shared_in);
    snp_res    = snoop_step(snp_cur, snp_kind);
    sel_snoop  = snp_active;
    lcl_ready  = !snp_active;
    lcl_hit    = lcl_valid && holds_copy(lcl_cur);
    snp_shared = snp_valid && (snp_kind == SNP_RD) && holds_copy(snp_cur);
    wr_en      = 1'b0;
    wr_line    = lcl_line;
    wr_state   = lcl_res.nxt;
    cmd        = BUS_NONE;
    if (snp_active) begin
      wr_line  = snp_line;
      wr_state = snp_res.nxt;
      cmd      = snp_res.cmd;
      wr_en    = holds_copy(snp_cur);
    end else if (lcl_valid) begin
      wr_en = 1'b1;
      cmd   = lcl_res.cmd;
    end
  end

endmodule

// File: rtl/mesi_coherence_ctrl.sv
module mesi_coherence_ctrl
  import mesi_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int IDX_W     = $clog2(NUM_LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lcl_valid_i,
  input  logic             lcl_write_i,
  input  logic [IDX_W-1:0] lcl_line_i,
  input  logic             shared_in_i,
  output logic             lcl_ready_o,
  output logic             lcl_hit_o,
  input  logic             snp_valid_i,
  input  logic [1:0]       snp_kind_i,
  input  logic [IDX_W-1:0] snp_line_i,
  output logic             snp_shared_o,
  output logic [2:0]       bus_cmd_o,
  output logic [IDX_W-1:0] bus_line_o,
  output logic             upd_valid_o,
  output logic [IDX_W-1:0] upd_line_o,
  output logic [1:0]       upd_state_o
);

  line_state_e      lcl_cur;
  line_state_e      snp_cur;
  line_state_e      wr_state;
  logic             wr_en;
  logic             sel_snoop;
  logic [IDX_W-1:0] wr_line;
  bus_cmd_e         next_cmd;
  snoop_kind_e      snp_kind;

  assign snp_kind = snoop_kind_e'(snp_kind_i);

  mesi_line_store #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_line    (wr_line),
    .wr_state   (wr_state),
    .rd_a_line  (lcl_line_i),
    .rd_a_state (lcl_cur),
    .rd_b_line  (snp_line_i),
    .rd_b_state (snp_cur)
  );

  mesi_txn_select #(.IDX_W(IDX_W)) u_select (
    .lcl_valid  (lcl_valid_i),
    .lcl_write  (lcl_write_i),
    .lcl_line   (lcl_line_i),
    .lcl_cur    (lcl_cur),
    .shared_in  (shared_in_i),
    .snp_valid  (snp_valid_i),
    .snp_kind   (snp_kind),
    .snp_line   (snp_line_i),
    .snp_cur    (snp_cur),
    .sel_snoop  (sel_snoop),
    .lcl_ready  (lcl_ready_o),
    .lcl_hit    (lcl_hit_o),
    .snp_shared (snp_shared_o),
    .wr_en      (wr_en),
    .wr_line    (wr_line),
    .wr_state   (wr_state),
    .cmd        (next_cmd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_cmd_o   <= BUS_NONE;
      bus_line_o  <= '0;
      upd_valid_o <= 1'b0;
      upd_line_o  <= '0;
      upd_state_o <= ST_I;
    end else begin
      bus_cmd_o   <= next_cmd;
      bus_line_o  <= wr_line;
      upd_valid_o <= wr_en;
      upd_line_o  <= wr_line;
      upd_state_o <= wr_state;
    end
  end

endmodule

// File: rtl/mesi_coherence_ctrl_chk.sv
module mesi_coherence_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       lcl_valid_i,
  input logic       snp_valid_i,
  input logic [1:0] snp_kind_i,
  input logic       lcl_ready_o,
  input logic       snp_shared_o,
  input logic [2:0] bus_cmd_o,
  input logic       upd_valid_o,
  input logic [1:0] upd_state_o,
  input logic       sel_snoop,
  input logic       wr_en
);

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> (bus_cmd_o == 3'd0 && !upd_valid_o));

  // R11
  cmd_has_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cmd_o != 3'd0 |-> upd_valid_o);

  // R11
  write_reported_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> upd_valid_o);

  // R3
  fill_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cmd_o == 3'd1 |-> (upd_state_o == 2'b10 || upd_state_o == 2'b01));

  // R5
  ownership_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd_o == 3'd2 || bus_cmd_o == 3'd3) |-> upd_state_o == 2'b11);

  // R6 R7
  writeback_leaves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cmd_o == 3'd4 |-> (upd_state_o == 2'b01 || upd_state_o == 2'b00));

  // R8
  snoop_blocks_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid_i && snp_kind_i != 2'd3) |-> (!lcl_ready_o && sel_snoop));

  // R6
  shared_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_shared_o |-> (snp_valid_i && snp_kind_i == 2'd0));

  // R9
  reserved_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid_i && snp_kind_i == 2'd3 && !lcl_valid_i) |=> (bus_cmd_o == 3'd0 && !upd_valid_o));

endmodule

bind mesi_coherence_ctrl mesi_coherence_ctrl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .lcl_valid_i  (lcl_valid_i),
  .snp_valid_i  (snp_valid_i),
  .snp_kind_i   (snp_kind_i),
  .lcl_ready_o  (lcl_ready_o),
  .snp_shared_o (snp_shared_o),
  .bus_cmd_o    (bus_cmd_o),
  .upd_valid_o  (upd_valid_o),
  .upd_state_o  (upd_state_o),
  .sel_snoop    (sel_snoop),
  .wr_en        (wr_en)
);

// File: tb/mesi_coherence_ctrl_test.sv
`timescale 1ns/1ps
module mesi_coherence_ctrl_test;

  localparam int LINES = 8;
  localparam int IW    = 3;

  // R2 encodings as restated by the bench
  localparam int SI = 0, SS = 1, SE = 2, SM = 3;
  localparam int CNONE = 0, CRD = 1, CRFO = 2, CUPG = 3, CWB = 4;
  localparam int KRD = 0, KRFO = 1, KINV = 2, KRSV = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          lcl_valid_i = 1'b0, lcl_write_i = 1'b0, shared_in_i = 1'b0;
  logic [IW-1:0] lcl_line_i = '0, snp_line_i = '0;
  logic          snp_valid_i = 1'b0;
  logic [1:0]    snp_kind_i = 2'd0;
  logic          lcl_ready_o, lcl_hit_o, snp_shared_o, upd_valid_o;
  logic [2:0]    bus_cmd_o;
  logic [IW-1:0] bus_line_o, upd_line_o;
  logic [1:0]    upd_state_o;

  int checks = 0;
  int errors = 0;
  int model [LINES];

  typedef struct {
    bit    upd;
    int    line;
    int    st;
    int    cmd;
    string tag;
  } exp_t;
  exp_t sb_q [$];

  always #2.5 clk = ~clk;

  mesi_coherence_ctrl uut (
    .clk(clk), .rst_n(rst_n),
    .lcl_valid_i(lcl_valid_i), .lcl_write_i(lcl_write_i), .lcl_line_i(lcl_line_i),
    .shared_in_i(shared_in_i), .lcl_ready_o(lcl_ready_o), .lcl_hit_o(lcl_hit_o),
    .snp_valid_i(snp_valid_i), .snp_kind_i(snp_kind_i), .snp_line_i(snp_line_i),
    .snp_shared_o(snp_shared_o), .bus_cmd_o(bus_cmd_o), .bus_line_o(bus_line_o),
    .upd_valid_o(upd_valid_o), .upd_line_o(upd_line_o), .upd_state_o(upd_state_o)
  );

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Driver: one cycle of stimulus, combinational checks, expected item pushed.
  task automatic step(bit lv, bit lw, int ll, bit sh, bit sv, int sk, int sl, string tag);
    exp_t e;
    bit   snp_act;
    int   cur;
    @(negedge clk);
    lcl_valid_i = lv; lcl_write_i = lw; lcl_line_i = IW'(ll); shared_in_i = sh;
    snp_valid_i = sv; snp_kind_i = 2'(sk); snp_line_i = IW'(sl);
    #1;
    snp_act = sv && sk != KRSV;
    check(tag, "lcl_ready", int'(lcl_ready_o), int'(!snp_act));
    check(tag, "lcl_hit", int'(lcl_hit_o), int'(lv && model[ll] != SI));
    check(tag, "snp_shared", int'(snp_shared_o), int'(sv && sk == KRD && model[sl] != SI));
    e.upd = 1'b0; e.line = 0; e.st = 0; e.cmd = CNONE; e.tag = tag;
    if (snp_act) begin
      cur = model[sl];
      if (cur != SI) begin
        e.upd = 1'b1; e.line = sl;
        e.cmd = (cur == SM) ? CWB : CNONE;
        e.st  = (sk == KRD) ? SS : SI;
        model[sl] = e.st;
      end
    end else if (lv) begin
      cur = model[ll];
      e.upd = 1'b1; e.line = ll;
      if (lw) begin
        e.st  = SM;
        e.cmd = (cur == SI) ? CRFO : (cur == SS) ? CUPG : CNONE;
      end else if (cur == SI) begin
        e.cmd = CRD;
        e.st  = sh ? SS : SE;
      end else begin
        e.st = cur;
      end
      model[ll] = e.st;
    end
    sb_q.push_back(e);
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, "idle");
  endtask

  // Monitor: compares registered outputs one cycle after each driven cycle (R11).
  always @(posedge clk) begin
    exp_t e;
    #1;
    if (sb_q.size() > 0) begin
      e = sb_q.pop_front();
      check(e.tag, "upd_valid", int'(upd_valid_o), int'(e.upd));
      check(e.tag, "bus_cmd", int'(bus_cmd_o), e.cmd);
      if (e.upd) begin
        check(e.tag, "upd_line", int'(upd_line_o), e.line);
        check(e.tag, "upd_state", int'(upd_state_o), e.st);
        if (e.cmd != CNONE) check(e.tag, "bus_line", int'(bus_line_o), e.line);
      end
    end
  end

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < LINES; i++) model[i] = SI;
    repeat (3) @(posedge clk);
    #1;
    check("R1", "bus_cmd in reset", int'(bus_cmd_o), CNONE);
    check("R1", "upd_valid in reset", int'(upd_valid_o), 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1", "bus_cmd after reset", int'(bus_cmd_o), CNONE);

    // R3 fills, R4 hit
    step(1, 0, 0, 0, 0, 0, 0, "R3 fill exclusive");
    step(1, 0, 0, 0, 0, 0, 0, "R4 read hit");
    step(1, 0, 1, 1, 0, 0, 0, "R3 fill shared");
    // R5 writes from each state
    step(1, 1, 1, 0, 0, 0, 0, "R5 write shared");
    step(1, 1, 0, 0, 0, 0, 0, "R5 write exclusive");
    step(1, 1, 2, 0, 0, 0, 0, "R5 write invalid");
    step(1, 1, 2, 0, 0, 0, 0, "R5 write modified");
    // R6 snooped reads
    step(0, 0, 0, 0, 1, KRD, 0, "R6 snoop read modified");
    step(0, 0, 0, 0, 1, KRD, 0, "R6 snoop read shared");
    step(1, 0, 3, 0, 0, 0, 0, "R3 fill line3");
    step(0, 0, 0, 0, 1, KRD, 3, "R6 snoop read exclusive");
    // R7 snooped ownership and invalidate
    step(0, 0, 0, 0, 1, KRFO, 2, "R7 snoop rfo modified");
    step(0, 0, 0, 0, 1, KINV, 1, "R7 snoop inv modified");
    step(0, 0, 0, 0, 1, KINV, 0, "R7 snoop inv shared");
    // R10 snoops to an invalid line
    step(0, 0, 0, 0, 1, KRD, 5, "R10 snoop read invalid");
    step(0, 0, 0, 0, 1, KRFO, 5, "R10 snoop rfo invalid");
    step(1, 0, 5, 0, 0, 0, 0, "R10 line5 still invalid");
    // R8 snoop holds off a local write
    step(1, 1, 4, 0, 1, KRD, 3, "R8 local blocked");
    step(1, 0, 4, 0, 0, 0, 0, "R8 blocked write left line invalid");
    // R9 reserved snoop kind
    step(1, 1, 3, 0, 1, KRSV, 3, "R9 reserved with local");
    step(0, 0, 0, 0, 1, KRSV, 3, "R9 reserved alone");
    step(1, 0, 3, 0, 0, 0, 0, "R9 line3 still modified");
    // Sweep every line: write then snoop-rfo
    for (int i = 0; i < LINES; i++) step(1, 1, i, 0, 0, 0, 0, "R5 sweep write");
    for (int i = 0; i < LINES; i++) step(0, 0, 0, 0, 1, KRFO, i, "R7 sweep rfo");
    for (int i = 0; i < LINES; i++) step(1, 0, i, 1, 0, 0, 0, "R3 sweep fill shared");
    idle();
    idle();
    idle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule